// File: doc/BRIEF.md
# Reduced-pin debug adapter control level and command unit

This unit sits beside the TAP state machine of a reduced-pin debug adapter. Control information reaches it through DR-scan paths. It does not read shifted data. It counts two things: how many DR scans pass through Update-DR without shifting, and how many clocks each scan spends in Shift-DR. From these counts it derives a control level from 0 to 7 and a lock flag. It turns off the clock and mode-select path to the downstream test controller once the level reaches 2.

At locked level 2, pairs of shifting DR scans form two-part commands. The Shift-DR clock count of the first scan is the command number and the count of the second scan is the data. The store-format command loads the data into a pending scan-format register. A check packet, signalled by a separate detector, then copies the pending code into the active format and raises advanced mode when that code selects an advanced format.

The adapter's state machine supplies the TAP state and a one-cycle step pulse for each TCK rising edge it acts on. All outputs are registered and change on the clock edge that samples the step pulse.

Top module: `cl_ctrl_unit`

## Requirements
- R1: `tap_state_i` uses this 4-bit code: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. Suppose the unit is unlocked and a step pulse reports Update-DR after a scan whose Shift-DR count is zero. Then the level rises by one on that edge.
- R2: The level saturates at 7. Further zero-count scans leave it at 7.
- R3: A step pulse that reports Update-DR with a nonzero Shift-DR count while the unit is unlocked sets the lock flag and leaves the level unchanged. While locked, later scans never change the level.
- R4: `gate_o` is 0 whenever the level is 2 or more, whether or not the unit is locked. It is 1 below level 2.
- R5: At locked level 2, each scan with a nonzero count reaching Update-DR is one part of a command. The first such scan gives the command number and the next gives the data. Zero-count scans are ignored.
- R6: Command 3 writes its data value into `fmt_o`. Any other command number leaves `fmt_o` unchanged. Writing `fmt_o` never changes `fmt_active_o` or `adv_o`.
- R7: A `check_i` pulse at locked level 2 copies `fmt_o` into `fmt_active_o` on the next edge. It sets `adv_o` to 1 when the copied code is 4 or more and to 0 otherwise. At any other level or lock state, the pulse is ignored.
- R8: A step pulse reporting Select-IR sets the level to 0, clears the lock flag and any half-received command, and sets `gate_o` to 1. `fmt_o`, `fmt_active_o` and `adv_o` keep their values.
- R9: A step pulse reporting Test-Logic-Reset clears the level, the lock flag, any half-received command, `fmt_active_o` and `adv_o`. `fmt_o` keeps its value.
- R10: The Shift-DR count is the number of step pulses reporting Shift-DR since the last step pulse reporting Capture-DR. It saturates at 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One-cycle pulse: the TAP state advanced on a TCK edge |
| tap_state_i | input | 4 | TAP state after the edge, code as in R1 |
| check_i | input | 1 | One-cycle pulse: a valid check packet was received |
| level_o | output | 3 | Control level |
| locked_o | output | 1 | Control level is locked |
| gate_o | output | 1 | 1 passes TCK/TMS to the downstream TAP |
| fmt_o | output | 6 | Pending scan-format register |
| fmt_active_o | output | 6 | Committed scan format |
| adv_o | output | 1 | Advanced mode active |

## Verification
The bench checks that the downstream gate closes at level 2 before any lock. A design that waited for the lock would leave the downstream TAP clocked during level selection. It checks that zero-count scans after a lock do not move the level, and that the level stops at 7 instead of wrapping to 0. It confirms that a stored format stays inert until a check packet arrives, and that a packet outside locked level 2 is ignored. It checks that an oversized data count commits 63 rather than a wrapped value. On exit through Select-IR, the format and advanced mode must survive. On exit through Test-Logic-Reset, advanced mode must be dropped.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [3:0] {
    ST_TLR = 4'd0, ST_RTI = 4'd1, ST_SEL_DR = 4'd2, ST_CAP_DR = 4'd3,
    ST_SHF_DR = 4'd4, ST_EX1_DR = 4'd5, ST_PAU_DR = 4'd6, ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8, ST_SEL_IR = 4'd9, ST_CAP_IR = 4'd10, ST_SHF_IR = 4'd11,
    ST_EX1_IR = 4'd12, ST_PAU_IR = 4'd13, ST_EX2_IR = 4'd14, ST_UPD_IR = 4'd15
  } tap_st_e;

  typedef struct packed {
    logic upd;
    logic cap;
    logic shf;
    logic sel_ir;
    logic tlr;
  } tap_ev_t;
endpackage

// File: rtl/cl_shift_cnt.sv
module cl_shift_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic             shf_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || cap_i)                 cnt_q <= '0;
    else if (shf_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R10: the count holds at its maximum
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && shf_i && !cap_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/cl_level_ctrl.sv
module cl_level_ctrl #(
  parameter int LVL_W    = 3,
  parameter int GATE_LVL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic             zero_cnt_i,
  input  logic             clr_i,
  output logic [LVL_W-1:0] level_o,
  output logic             locked_o,
  output logic             gate_o
);
  localparam logic [LVL_W-1:0] LVL_MAX  = '1;
  localparam logic [LVL_W-1:0] LVL_GATE = LVL_W'(GATE_LVL);

  logic [LVL_W-1:0] level_q, level_d;
  logic             locked_q, locked_d;
  logic             gate_q;

  always_comb begin
    level_d  = level_q;
    locked_d = locked_q;
    if (clr_i) begin
      level_d  = '0;
      locked_d = 1'b0;
    end else if (upd_i && !locked_q) begin
      if (!zero_cnt_i)            locked_d = 1'b1;
      else if (level_q != LVL_MAX) level_d = level_q + LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= '0;
      locked_q <= 1'b0;
      gate_q   <= 1'b1;
    end else begin
      level_q  <= level_d;
      locked_q <= locked_d;
      gate_q   <= (level_d < LVL_GATE);
    end
  end

  assign level_o  = level_q;
  assign locked_o = locked_q;
  assign gate_o   = gate_q;

  // R2: the level only falls through a clear event
  p_lvl_mono_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> level_q >= $past(level_q));
  // R3: a locked level does not move without a clear
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !clr_i) |=> $stable(level_q));
endmodule

// File: rtl/cl_cmd_dec.sv
module cl_cmd_dec #(
  parameter int CNT_W     = 6,
  parameter int LVL_W     = 3,
  parameter int GATE_LVL  = 2,
  parameter int CMD_STFMT = 3,
  parameter int ADV_MIN   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             locked_i,
  input  logic             sel_ir_i,
  input  logic             tlr_i,
  input  logic             check_i,
  output logic [CNT_W-1:0] fmt_o,
  output logic [CNT_W-1:0] fmt_act_o,
  output logic             adv_o
);
  localparam logic [CNT_W-1:0] CMD_CODE = CNT_W'(CMD_STFMT);
  localparam logic [CNT_W-1:0] ADV_CODE = CNT_W'(ADV_MIN);
  localparam logic [LVL_W-1:0] CMD_LVL  = LVL_W'(GATE_LVL);

  logic             cmd_ok;
  logic             part_q;
  logic [CNT_W-1:0] cmd_q, fmt_q, act_q;
  logic             adv_q;

  assign cmd_ok = locked_i && (level_i == CMD_LVL);

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= 1'b0;
      cmd_q  <= '0;
      fmt_q  <= '0;
      act_q  <= '0;
      adv_q  <= 1'b0;
    end else if (tlr_i) begin
      part_q <= 1'b0;
      act_q  <= '0;
      adv_q  <= 1'b0;
    end else if (sel_ir_i) begin
      part_q <= 1'b0;
    end else begin
      if (cmd_ok && upd_i && cnt_i != '0) begin
        if (!part_q) begin
          cmd_q  <= cnt_i;
          part_q <= 1'b1;
        end else begin
          part_q <= 1'b0;
          if (cmd_q == CMD_CODE) fmt_q <= cnt_i;
        end
      end
      if (cmd_ok && check_i) begin
        act_q <= fmt_q;
        adv_q <= (fmt_q >= ADV_CODE);
      end
    end
  end

  assign fmt_o     = fmt_q;
  assign fmt_act_o = act_q;
  assign adv_o     = adv_q;

  // R7: advanced mode only rises after a check packet
  p_adv_chk_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(adv_q) |-> $past(check_i));
  // R9: test-logic-reset drops advanced mode
  p_tlr_adv_r9: assert property (@(posedge clk) disable iff (rst)
    tlr_i |=> (!adv_q && act_q == '0));
endmodule

// File: rtl/cl_ctrl_unit.sv
module cl_ctrl_unit #(
  parameter int LVL_W     = 3,
  parameter int CNT_W     = 6,
  parameter int GATE_LVL  = 2,
  parameter int CMD_STFMT = 3,
  parameter int ADV_MIN   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [3:0]       tap_state_i,
  input  logic             check_i,
  output logic [LVL_W-1:0] level_o,
  output logic             locked_o,
  output logic             gate_o,
  output logic [CNT_W-1:0] fmt_o,
  output logic [CNT_W-1:0] fmt_active_o,
  output logic             adv_o
);
  import cl_pkg::*;

  tap_ev_t          ev;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ev.upd    = step_i && (tap_state_i == ST_UPD_DR);
    ev.cap    = step_i && (tap_state_i == ST_CAP_DR);
    ev.shf    = step_i && (tap_state_i == ST_SHF_DR);
    ev.sel_ir = step_i && (tap_state_i == ST_SEL_IR);
    ev.tlr    = step_i && (tap_state_i == ST_TLR);
  end

  cl_shift_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cap_i(ev.cap), .shf_i(ev.shf), .cnt_o(cnt)
  );

  cl_level_ctrl #(.LVL_W(LVL_W), .GATE_LVL(GATE_LVL)) u_lvl (
    .clk(clk), .rst(rst), .upd_i(ev.upd), .zero_cnt_i(cnt == '0),
    .clr_i(ev.sel_ir || ev.tlr), .level_o(level_o), .locked_o(locked_o),
    .gate_o(gate_o)
  );

  cl_cmd_dec #(.CNT_W(CNT_W), .LVL_W(LVL_W), .GATE_LVL(GATE_LVL),
               .CMD_STFMT(CMD_STFMT), .ADV_MIN(ADV_MIN)) u_cmd (
    .clk(clk), .rst(rst), .upd_i(ev.upd), .cnt_i(cnt), .level_i(level_o),
    .locked_i(locked_o), .sel_ir_i(ev.sel_ir), .tlr_i(ev.tlr),
    .check_i(check_i), .fmt_o(fmt_o), .fmt_act_o(fmt_active_o), .adv_o(adv_o)
  );

  // R4: downstream path closed from level 2 upward
  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (level_o >= LVL_W'(GATE_LVL)) |-> !gate_o);
  // R8: leaving through select-IR reopens the gate and unlocks
  p_selir_r8: assert property (@(posedge clk) disable iff (rst)
    ev.sel_ir |=> (gate_o && !locked_o && level_o == '0));
  // R1: an unlocked zero-count update advances by one below the top level
  p_zbs_step_r1: assert property (@(posedge clk) disable iff (rst)
    (ev.upd && !locked_o && cnt == '0 && level_o != '1) |=>
      level_o == $past(level_o) + LVL_W'(1));
endmodule

// File: tb/sim_cl_ctrl_unit.sv
module sim_cl_ctrl_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_i = 1'b0;
  logic [3:0] tap_state_i = 4'd1;
  logic       check_i = 1'b0;
  logic [2:0] level_o;
  logic       locked_o, gate_o, adv_o;
  logic [5:0] fmt_o, fmt_active_o;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cl_ctrl_unit u0 (
    .clk(clk), .rst(rst), .step_i(step_i), .tap_state_i(tap_state_i),
    .check_i(check_i), .level_o(level_o), .locked_o(locked_o), .gate_o(gate_o),
    .fmt_o(fmt_o), .fmt_active_o(fmt_active_o), .adv_o(adv_o)
  );

  task automatic chk(input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; step_i = 1'b0; check_i = 1'b0; tap_state_i = 4'd1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic step(input logic [3:0] s);
    @(negedge clk); tap_state_i = s; step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
  endtask

  task automatic scan(input int n);
    step(4'd2); step(4'd3);
    for (int i = 0; i < n; i++) step(4'd4);
    step(4'd5); step(4'd8); step(4'd1);
  endtask

  task automatic pulse_check();
    @(negedge clk); check_i = 1'b1;
    @(negedge clk); check_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R4 reset level", level_o, 0);
    chk("R4 reset gate", gate_o, 1);
    chk("R9 reset adv", adv_o, 0);
  endtask

  task automatic t_levels();
    do_reset();
    scan(0);
    chk("R1 one ZBS level", level_o, 1);
    chk("R4 gate open at 1", gate_o, 1);
    scan(0);
    chk("R1 two ZBS level", level_o, 2);
    chk("R4 gate closed unlocked", gate_o, 0);
    chk("R3 not locked yet", locked_o, 0);
    scan(1);
    chk("R3 lock set", locked_o, 1);
    chk("R3 level kept by lock", level_o, 2);
    scan(0);
    chk("R3 ZBS after lock", level_o, 2);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 9; i++) scan(0);
    chk("R2 level saturates", level_o, 7);
  endtask

  task automatic t_commands();
    do_reset();
    pulse_check();
    chk("R7 check ignored unlocked adv", adv_o, 0);
    scan(0); scan(0); scan(2);
    scan(5); scan(12);
    chk("R6 other command keeps fmt", fmt_o, 0);
    scan(3); scan(0); scan(9);
    chk("R5 R6 store format", fmt_o, 9);
    chk("R6 active unchanged", fmt_active_o, 0);
    chk("R6 adv unchanged", adv_o, 0);
    pulse_check();
    chk("R7 commit active", fmt_active_o, 9);
    chk("R7 advanced set", adv_o, 1);
    step(4'd2); step(4'd9); step(4'd10); step(4'd12); step(4'd15); step(4'd1);
    chk("R8 level cleared", level_o, 0);
    chk("R8 gate reopened", gate_o, 1);
    chk("R8 unlocked", locked_o, 0);
    chk("R8 adv kept", adv_o, 1);
    chk("R8 fmt kept", fmt_o, 9);
    step(4'd0);
    chk("R9 adv cleared", adv_o, 0);
    chk("R9 active cleared", fmt_active_o, 0);
    chk("R9 fmt kept", fmt_o, 9);
  endtask

  task automatic t_std_fmt_and_sat();
    do_reset();
    scan(0); scan(0); scan(1);
    scan(3); scan(2);
    pulse_check();
    chk("R7 standard code active", fmt_active_o, 2);
    chk("R7 standard code no adv", adv_o, 0);
    scan(3); scan(70);
    chk("R10 count saturates", fmt_o, 63);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_levels();
    t_saturate();
    t_commands();
    t_std_fmt_and_sat();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule